// File: doc/BRIEF.md
# Serial Link Power and Lock Sequencer

This block decides what the output stage of a serial link transmitter does at any moment. It watches an asynchronous run request, a flag that says the input-buffer supply is present, and a 2-bit clock band select. From these it drives three control lines for the analog side: enable for the clock-multiplying PLL, enable for the on-die termination, and enable for the output driver. It also raises a lock-done flag. The analog PLL and termination are not modelled; they appear only as these control outputs.

The sequencer has three states. In OFF, everything is disabled and the output floats. When the run request is high and the supply is present, it moves to LOCKING. There it starts the PLL and switches the termination in, so the differential output sits at zero, while a counter runs for a fixed number of parallel-clock cycles that stands in for a lock detector. When the count is complete it moves to ACTIVE and the driver is enabled. A change of band select while the link is up starts the count again. Dropping the run request, or losing the supply, returns the block to OFF at once.

Two status items help the system around the block. One reports the serial rate range that belongs to the selected clock band, which is twenty serial bits per parallel clock. The other is a watchdog that raises a fault when the data-enable line stays still for too long while the link is ACTIVE, because the receiving end needs that line to keep toggling.

Top module: `link_power_seq`

## Requirements
- R1: While rst_n is low, pll_en, term_en, drive_en, lock_done and de_fault are all 0.
- R2: In OFF (the synchronized run condition is low), pll_en, term_en and drive_en are all 0, and the block stays in OFF for as long as the condition remains low.
- R3: In LOCKING, pll_en and term_en are 1 and drive_en is 0. LOCKING lasts exactly LOCK_CYCLES clock cycles (16385 by default).
- R4: Once the count completes, the block enters ACTIVE. There drive_en and lock_done are 1, and pll_en and term_en stay at 1.
- R5: The run condition (pwr_on AND supply_ok) passes through SYNC_STAGES flops (2 by default). After pwr_on rises, term_en is still 0 after the second clock edge and is 1 after the third.
- R6: If pwr_on falls during LOCKING or ACTIVE, all enables drop after the third clock edge and the count is abandoned. The next power-up runs a full LOCK_CYCLES count.
- R7: supply_ok low forces the OFF state, with the same latency as R6, whatever pwr_on is.
- R8: A change of range_sel during LOCKING or ACTIVE puts the block into LOCKING on the next edge (drive_en 0, term_en 1) and starts a full LOCK_CYCLES count. A change during OFF has no effect on the enables.
- R9: rate_lo_mbps and rate_hi_mbps give 20 times the band edges in MHz for the registered range_sel, one edge after it changes. The bands are 0 for 3-5, 1 for 5-10, 2 for 10-20 and 3 for 20-35, which gives 60/100, 100/200, 200/400 and 400/700.
- R10: In ACTIVE, de_fault rises after WD_LIMIT consecutive edges with no change on de_in. It clears on the edge after a change, and it is 0 outside ACTIVE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_on | input | 1 | Asynchronous run request; low powers the link down |
| supply_ok | input | 1 | Input-buffer supply present; low forces power-down |
| range_sel | input | 2 | Parallel clock band select |
| de_in | input | 1 | Data-enable line watched for activity |
| pll_en | output | 1 | PLL run enable |
| term_en | output | 1 | Output termination enable |
| drive_en | output | 1 | Serial output driver enable |
| lock_done | output | 1 | Lock count complete, link active |
| de_fault | output | 1 | Data-enable inactivity fault |
| rate_lo_mbps | output | 10 | Lower serial rate bound of the selected band |
| rate_hi_mbps | output | 10 | Upper serial rate bound of the selected band |

## Verification
Suppose the state or the lock counter is wrong. That shows directly as the wrong combination of enables. It also shows as a LOCKING window whose length, counted at the ports, differs from LOCK_CYCLES, whether too short, too long or carried over from an aborted attempt. A synchronizer of the wrong depth moves the first term_en edge away from the third clock. A watchdog counter that clears or saturates in the wrong place moves the rise of de_fault away from edge WD_LIMIT of ACTIVE.

// File: rtl/lpseq_pkg.sv
package lpseq_pkg;

  typedef enum logic [1:0] {
    ST_OFF     = 2'd0,
    ST_LOCKING = 2'd1,
    ST_ACTIVE  = 2'd2
  } seq_state_e;

  localparam int RATE_W     = 10;
  localparam int SER_FACTOR = 20;

  // Lower edge of the parallel clock band in MHz
  function automatic int band_lo_mhz(input logic [1:0] sel);
    case (sel)
      2'd0:    return 3;
      2'd1:    return 5;
      2'd2:    return 10;
      default: return 20;
    endcase
  endfunction

  // Upper edge of the parallel clock band in MHz
  function automatic int band_hi_mhz(input logic [1:0] sel);
    case (sel)
      2'd0:    return 5;
      2'd1:    return 10;
      2'd2:    return 20;
      default: return 35;
    endcase
  endfunction

  function automatic logic [RATE_W-1:0] ser_rate_lo(input logic [1:0] sel);
    return RATE_W'(SER_FACTOR * band_lo_mhz(sel));
  endfunction

  function automatic logic [RATE_W-1:0] ser_rate_hi(input logic [1:0] sel);
    return RATE_W'(SER_FACTOR * band_hi_mhz(sel));
  endfunction

endpackage

// File: rtl/lpseq_sync.sv
module lpseq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
    end else begin
      shreg[0] <= d;
      for (int i = 1; i < STAGES; i++) shreg[i] <= shreg[i-1];
    end
  end

  assign q = shreg[STAGES-1];
endmodule

// File: rtl/lpseq_lock_timer.sv
module lpseq_lock_timer #(
  parameter int LOCK_CYCLES = 16385
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic hit
);
  localparam int          CW   = $clog2(LOCK_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(LOCK_CYCLES - 1);

  logic [CW-1:0] cnt;

  assign hit = run && !restart && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt <= '0;
    else if (!run || restart || hit) cnt <= '0;
    else                            cnt <= cnt + 1'b1;
  end

  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt <= LAST));

  // R3
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && restart) |=> (cnt == '0));
endmodule

// File: rtl/lpseq_de_watch.sv
module lpseq_de_watch #(
  parameter int WD_ENABLE = 1,
  parameter int WD_LIMIT  = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic de_in,
  output logic fault
);
  generate
    if (WD_ENABLE != 0) begin : g_wd
      localparam int            WW  = $clog2(WD_LIMIT + 1);
      localparam logic [WW-1:0] LIM = WW'(WD_LIMIT);

      logic          de_q;
      logic [WW-1:0] idle_cnt;
      logic          de_toggle;

      assign de_toggle = de_in ^ de_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          de_q     <= 1'b0;
          idle_cnt <= '0;
        end else begin
          de_q <= de_in;
          if (!active || de_toggle) idle_cnt <= '0;
          else if (idle_cnt != LIM) idle_cnt <= idle_cnt + 1'b1;
        end
      end

      assign fault = active && (idle_cnt == LIM);

      // R10
      toggle_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        de_toggle |=> !fault);
    end else begin : g_nowd
      logic unused_wd;
      assign unused_wd = ^{active, de_in, clk, rst_n};
      assign fault = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/link_power_seq.sv
module link_power_seq
  import lpseq_pkg::*;
#(
  parameter int LOCK_CYCLES = 16385,
  parameter int SYNC_STAGES = 2,
  parameter int WD_ENABLE   = 1,
  parameter int WD_LIMIT    = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_on,
  input  logic              supply_ok,
  input  logic [1:0]        range_sel,
  input  logic              de_in,
  output logic              pll_en,
  output logic              term_en,
  output logic              drive_en,
  output logic              lock_done,
  output logic              de_fault,
  output logic [RATE_W-1:0] rate_lo_mbps,
  output logic [RATE_W-1:0] rate_hi_mbps
);
  logic       run_raw, run_s;
  logic [1:0] range_q;
  logic       range_chg;
  logic       lock_hit;
  seq_state_e state, state_nx;

  // Missing supply acts as a forced power-down
  assign run_raw = pwr_on & supply_ok;

  lpseq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(run_raw), .q(run_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) range_q <= 2'd0;
    else        range_q <= range_sel;
  end

  assign range_chg = (range_sel != range_q);

  lpseq_lock_timer #(.LOCK_CYCLES(LOCK_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n),
    .run(state == ST_LOCKING), .restart(range_chg), .hit(lock_hit)
  );

  always_comb begin
    state_nx = state;
    if (!run_s) begin
      state_nx = ST_OFF;
    end else begin
      case (state)
        ST_OFF:     state_nx = ST_LOCKING;
        ST_LOCKING: if (range_chg)     state_nx = ST_LOCKING;
                    else if (lock_hit) state_nx = ST_ACTIVE;
        ST_ACTIVE:  if (range_chg)     state_nx = ST_LOCKING;
        default:    state_nx = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_OFF;
    else        state <= state_nx;
  end

  assign pll_en    = (state != ST_OFF);
  assign term_en   = (state != ST_OFF);
  assign drive_en  = (state == ST_ACTIVE);
  assign lock_done = (state == ST_ACTIVE);

  lpseq_de_watch #(.WD_ENABLE(WD_ENABLE), .WD_LIMIT(WD_LIMIT)) u_wd (
    .clk(clk), .rst_n(rst_n), .active(state == ST_ACTIVE),
    .de_in(de_in), .fault(de_fault)
  );

  assign rate_lo_mbps = ser_rate_lo(range_q);
  assign rate_hi_mbps = ser_rate_hi(range_q);

  // R2
  off_follows_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_s |=> (state == ST_OFF));

  // R4
  drive_needs_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drive_en) |-> $past(lock_hit));

  // R4
  lock_enters_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_s && lock_hit && state == ST_LOCKING) |=> drive_en);

  // R8
  range_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_s && range_chg && state != ST_OFF) |=> (state == ST_LOCKING));
endmodule

// File: tb/tb_link_power_seq.sv
`timescale 1ns/1ps
module tb_link_power_seq;
  localparam int LOCK_SMALL = 20;
  localparam int WD_SMALL   = 8;
  localparam int LOCK_FULL  = 16385;

  logic clk = 1'b0;
  logic rst_n, pwr_on, pwr_on_full, supply_ok, de_in;
  logic [1:0] range_sel;
  logic pll_en, term_en, drive_en, lock_done, de_fault;
  logic [9:0] rate_lo, rate_hi;
  logic f_pll, f_term, f_drive, f_done, f_fault;
  logic [9:0] f_lo, f_hi;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  link_power_seq #(.LOCK_CYCLES(LOCK_SMALL), .SYNC_STAGES(2),
                   .WD_ENABLE(1), .WD_LIMIT(WD_SMALL)) dut (
    .clk(clk), .rst_n(rst_n), .pwr_on(pwr_on), .supply_ok(supply_ok),
    .range_sel(range_sel), .de_in(de_in), .pll_en(pll_en), .term_en(term_en),
    .drive_en(drive_en), .lock_done(lock_done), .de_fault(de_fault),
    .rate_lo_mbps(rate_lo), .rate_hi_mbps(rate_hi)
  );

  link_power_seq dut_full (
    .clk(clk), .rst_n(rst_n), .pwr_on(pwr_on_full), .supply_ok(supply_ok),
    .range_sel(range_sel), .de_in(de_in), .pll_en(f_pll), .term_en(f_term),
    .drive_en(f_drive), .lock_done(f_done), .de_fault(f_fault),
    .rate_lo_mbps(f_lo), .rate_hi_mbps(f_hi)
  );

  function automatic int exp_lo(input int s);
    return (s == 0) ? 60 : (100 << (s - 1));
  endfunction

  function automatic int exp_hi(input int s);
    return (s == 3) ? 700 : (100 << s);
  endfunction

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_eq(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Counts negedges spent in the terminated idle state
  task automatic measure_lock(input bit full, output int c);
    c = 0;
    while ((full ? (!f_drive && f_term) : (!drive_en && term_en)) && c < 100000) begin
      c++;
      step(1);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #1000000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    int c;
    int w;
    rst_n = 1'b0; pwr_on = 1'b0; pwr_on_full = 1'b0; supply_ok = 1'b1;
    range_sel = 2'd0; de_in = 1'b0;
    step(3);
    // R1 reset state
    check_eq("R1 pll_en", pll_en, 0);
    check_eq("R1 term_en", term_en, 0);
    check_eq("R1 drive_en", drive_en, 0);
    check_eq("R1 lock_done", lock_done, 0);
    check_eq("R1 de_fault", de_fault, 0);
    rst_n = 1'b1;
    step(6);
    // R2 stays off with pwr_on low
    check_eq("R2 term_en", term_en, 0);
    check_eq("R2 pll_en", pll_en, 0);
    check_eq("R2 drive_en", drive_en, 0);

    for (int s = 0; s < 4; s++) begin
      range_sel = 2'(s);
      step(1);
      pwr_on = 1'b1;
      step(2);
      check_eq("R5 term_en after two edges", term_en, 0);
      step(1);
      check_eq("R5 term_en after three edges", term_en, 1);
      check_eq("R3 pll_en locking", pll_en, 1);
      check_eq("R3 drive_en locking", drive_en, 0);
      measure_lock(1'b0, c);
      check_eq("R3 lock length", c, LOCK_SMALL);
      check_eq("R4 drive_en", drive_en, 1);
      check_eq("R4 lock_done", lock_done, 1);
      check_eq("R4 term_en", term_en, 1);
      check_eq("R9 rate_lo", rate_lo, exp_lo(s));
      check_eq("R9 rate_hi", rate_hi, exp_hi(s));
      for (int k = 0; k < 20; k++) begin
        de_in = ~de_in;
        step(1);
      end
      check_eq("R10 no fault while toggling", de_fault, 0);
      pwr_on = 1'b0;
      step(2);
      check_eq("R6 drive_en before sync", drive_en, 1);
      step(1);
      check_eq("R6 drive_en off", drive_en, 0);
      check_eq("R2 term_en off", term_en, 0);
      check_eq("R2 pll_en off", pll_en, 0);
      check_eq("R10 fault off outside active", de_fault, 0);
    end

    // R6 abort in mid-count, then full count again
    pwr_on = 1'b1;
    step(8);
    check_eq("R6 locking mid-count", term_en && !drive_en, 1);
    pwr_on = 1'b0;
    step(3);
    check_eq("R6 aborted term_en", term_en, 0);
    step(2);
    pwr_on = 1'b1;
    step(3);
    measure_lock(1'b0, c);
    check_eq("R6 full count after abort", c, LOCK_SMALL);

    // R8 range change while active
    range_sel = 2'd1;
    step(1);
    check_eq("R8 drive_en dropped", drive_en, 0);
    check_eq("R8 term_en kept", term_en, 1);
    check_eq("R9 rate_lo new band", rate_lo, exp_lo(1));
    check_eq("R9 rate_hi new band", rate_hi, exp_hi(1));
    measure_lock(1'b0, c);
    check_eq("R8 relock length", c, LOCK_SMALL);

    // R8 range change during locking
    range_sel = 2'd2;
    step(1);
    step(6);
    range_sel = 2'd0;
    step(1);
    measure_lock(1'b0, c);
    check_eq("R8 restart in locking", c, LOCK_SMALL);

    // R10 inactivity fault
    w = 0;
    while (!de_fault && w < 100) begin
      step(1);
      w++;
    end
    check_eq("R10 fault delay", w, WD_SMALL);
    de_in = ~de_in;
    step(1);
    check_eq("R10 fault cleared", de_fault, 0);

    // R7 supply loss
    supply_ok = 1'b0;
    step(2);
    check_eq("R7 drive_en before sync", drive_en, 1);
    step(1);
    check_eq("R7 drive_en off", drive_en, 0);
    check_eq("R7 term_en off", term_en, 0);
    step(30);
    check_eq("R7 held off", term_en, 0);
    supply_ok = 1'b1;
    step(3);
    measure_lock(1'b0, c);
    check_eq("R7 relock after supply", c, LOCK_SMALL);

    // R8 range change while off has no effect
    pwr_on = 1'b0;
    step(3);
    range_sel = 2'd3;
    step(5);
    check_eq("R8 off ignores range", term_en, 0);
    check_eq("R8 off drive_en", drive_en, 0);
    check_eq("R9 rate_hi in off", rate_hi, exp_hi(3));

    // R3 default depth
    pwr_on_full = 1'b1;
    step(3);
    check_eq("R5 full term_en", f_term, 1);
    measure_lock(1'b1, c);
    check_eq("R3 full lock length", c, LOCK_FULL);
    check_eq("R4 full drive_en", f_drive, 1);

    finish_run();
  end
endmodule